// File: doc/BRIEF.md
# Flag-Setting Two-Address ALU

This block is the execute-stage arithmetic and logic unit of a small 16-bit processor whose instructions name two registers, one of which is both an operand and the destination. Each cycle it takes the destination register's current value and a second operand. That operand is either a source register or an immediate already widened by decode. It then returns the value to write back and a write-enable for the register file.

It also owns the five status flags. Only the add, subtract and compare groups may change them, and each group changes only its own subset. Add and subtract report carry and signed overflow. Compare reports equality and the unsigned and signed less-than relations, and it writes no register. The flags are held in a register inside the block and are updated on the clock edge that ends an issued operation.

Top module: `alu2_core`

## Requirements
- R1: While rst_ni is low, flags_o reads all zero. The bit layout of flags_o is {Z, N, L, F, C}, with Z at bit 4 and C at bit 0.
- R2: flags_o changes only on a rising clock edge where valid_i is high and op_i is ADD, SUB or CMP. Every other opcode keeps all five flags, and so does any cycle with valid_i low.
- R3: ADD (op_i = 0) drives result_o = dst + opnd mod 2^16 with wr_en_o high. On the next edge, C takes the carry out and F takes the signed overflow. N, L and Z keep their values.
- R4: SUB (op_i = 1) drives result_o = dst - opnd mod 2^16 with wr_en_o high. On the next edge, C takes the carry out of dst + ~opnd + 1 (high when dst >= opnd unsigned) and F takes the signed overflow of dst - opnd. N, L and Z keep their values.
- R5: CMP (op_i = 2) holds wr_en_o low and result_o at zero. On the next edge, Z = (dst == opnd), L = (dst < opnd unsigned) and N = (dst < opnd signed). C and F keep their values.
- R6: AND (3), OR (4) and XOR (5) return the bitwise function of dst and opnd. MOV (6) returns opnd. All four raise wr_en_o.
- R7: LSH (7) shifts dst by exactly one bit, filling with zero. The direction comes from opnd read as signed: positive shifts left, negative shifts right, and zero returns dst unchanged. wr_en_o is high.
- R8: LUI (8) returns imm_i[7:0] in bits 15:8 and zeros in bits 7:0, whatever use_imm_i is. wr_en_o is high.
- R9: The second operand opnd is imm_i when use_imm_i is high and src_i otherwise.
- R10: wr_en_o is high exactly when valid_i is high and op_i is one of 0, 1, 3, 4, 5, 6, 7 or 8. result_o is zero whenever wr_en_o is low, which covers opcodes 9 to 15 and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Select imm_i instead of src_i as operand |
| src_i | input | 16 | Source register value |
| imm_i | input | 16 | Immediate, already widened by decode |
| dst_i | input | 16 | Destination register value, first operand |
| result_o | output | 16 | Value to write back to the destination |
| wr_en_o | output | 1 | Register write-enable |
| flags_o | output | 5 | Status flags {Z, N, L, F, C} |

## Verification
The flag-holding properties assume that op_i, valid_i and the operands are settled and free of X at each rising edge. The stimulus meets this by changing every input only on the falling edge. The comparison checks inside the adder apply only to operands with no unknown bits, and the bench never leaves an input undriven after reset. Every opcode is swept over all pairs drawn from a set of sixteen boundary values, including zero, all ones, and the values just below and above the signed limits. The operand source alternates between register and immediate, and the unused source is loaded with a conflicting value. Undefined opcodes and idle cycles are inserted so that the flag-hold rules are exercised.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_MOV = 4'd6,
    OP_LSH = 4'd7,
    OP_LUI = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic l;
    logic f;
    logic c;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu2_arith.sv
// Shared adder for add, subtract and compare.
module alu2_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              eq_o,
  output logic              ult_o,
  output logic              slt_o
);

  logic [DATA_W-1:0] b_op;

  assign b_op = sub_i ? ~opnd_i : opnd_i;
  assign {carry_o, sum_o} = {1'b0, dst_i} + {1'b0, b_op} + (DATA_W+1)'(sub_i);

  // Overflow: like-signed inputs producing a differently-signed sum.
  assign ovf_o = (dst_i[DATA_W-1] == b_op[DATA_W-1]) && (sum_o[DATA_W-1] != dst_i[DATA_W-1]);
  assign eq_o  = (sum_o == '0);
  assign ult_o = ~carry_o;
  assign slt_o = sum_o[DATA_W-1] ^ ovf_o;

  always_comb begin
    if (sub_i && !$isunknown({dst_i, opnd_i})) begin
      a_r5_ult_matches: assert (ult_o == (dst_i < opnd_i))
        else $error("unsigned less disagrees with compare");
      a_r5_slt_matches: assert (slt_o == ($signed(dst_i) < $signed(opnd_i)))
        else $error("signed less disagrees with compare");
    end
  end

endmodule

// File: rtl/alu2_logic.sv
// Bitwise, move, one-bit shift and upper-immediate load.
module alu2_logic
  import alu2_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [HALF_W-1:0] imm_lo_i,
  output logic [DATA_W-1:0] result_o
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    if (opnd_i == '0)              shifted = dst_i;
    else if (opnd_i[DATA_W-1])     shifted = {1'b0, dst_i[DATA_W-1:1]};
    else                           shifted = {dst_i[DATA_W-2:0], 1'b0};
  end

  always_comb begin
    unique case (op_i)
      OP_AND:  result_o = dst_i & opnd_i;
      OP_OR:   result_o = dst_i | opnd_i;
      OP_XOR:  result_o = dst_i ^ opnd_i;
      OP_MOV:  result_o = opnd_i;
      OP_LSH:  result_o = shifted;
      OP_LUI:  result_o = {imm_lo_i, {(DATA_W-HALF_W){1'b0}}};
      default: result_o = '0;
    endcase
  end

endmodule

// File: rtl/alu2_flags.sv
// Status flag register with per-class update masks.
module alu2_flags
  import alu2_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_arith_i,
  input  logic       upd_cmp_i,
  input  logic       carry_i,
  input  logic       ovf_i,
  input  logic       eq_i,
  input  logic       ult_i,
  input  logic       slt_i,
  output alu_flags_t flags_o
);

  alu_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_arith_i) begin
      flags_q.c <= carry_i;
      flags_q.f <= ovf_i;
    end else if (upd_cmp_i) begin
      flags_q.z <= eq_i;
      flags_q.l <= ult_i;
      flags_q.n <= slt_i;
    end
  end

  assign flags_o = flags_q;

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_arith_i && !upd_cmp_i) |=> $stable(flags_q));

  a_r3_arith_keeps_znl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_arith_i |=> $stable({flags_q.z, flags_q.n, flags_q.l}));

  a_r5_cmp_keeps_cf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_cmp_i |=> $stable({flags_q.c, flags_q.f}));

  a_r5_cmp_equal_sets_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_cmp_i && eq_i) |=> flags_q.z);

endmodule

// File: rtl/alu2_core.sv
module alu2_core
  import alu2_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] logic_res;
  logic              carry, ovf, eq, ult, slt;
  logic              is_arith, is_cmp, is_logic;
  alu_flags_t        flags;

  assign opnd = use_imm_i ? imm_i : src_i;

  always_comb begin
    is_arith = 1'b0;
    is_cmp   = 1'b0;
    is_logic = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: is_arith = 1'b1;
      OP_CMP:         is_cmp   = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_MOV, OP_LSH, OP_LUI: is_logic = 1'b1;
      default: ;
    endcase
  end

  alu2_arith #(.DATA_W(DATA_W)) i_arith (
    .dst_i   (dst_i),
    .opnd_i  (opnd),
    .sub_i   (op_i != OP_ADD),
    .sum_o   (sum),
    .carry_o (carry),
    .ovf_o   (ovf),
    .eq_o    (eq),
    .ult_o   (ult),
    .slt_o   (slt)
  );

  alu2_logic #(.DATA_W(DATA_W)) i_logic (
    .op_i     (op_i),
    .dst_i    (dst_i),
    .opnd_i   (opnd),
    .imm_lo_i (imm_i[HALF_W-1:0]),
    .result_o (logic_res)
  );

  alu2_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_arith_i (valid_i && is_arith),
    .upd_cmp_i   (valid_i && is_cmp),
    .carry_i     (carry),
    .ovf_i       (ovf),
    .eq_i        (eq),
    .ult_i       (ult),
    .slt_i       (slt),
    .flags_o     (flags)
  );

  assign wr_en_o  = valid_i && (is_arith || is_logic);
  assign result_o = !wr_en_o ? '0 : (is_arith ? sum : logic_res);
  assign flags_o  = flags;

  a_r5_cmp_never_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP) |-> (!wr_en_o && result_o == '0));

  a_r8_lui_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_LUI) |-> (result_o[HALF_W-1:0] == '0));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wr_en_o && result_o == '0));

endmodule

// File: tb/test_alu2_core.sv
module test_alu2_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [15:0] src = '0, imm = '0, dst = '0;
  logic [15:0] result;
  logic        wr_en;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] exp_flags = '0;   // {Z,N,L,F,C}
  logic [15:0] vals [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu2_core i_alu2_core (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .use_imm_i(use_imm),
    .src_i(src), .imm_i(imm), .dst_i(dst),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (op %0d dst %h src %h imm %h use_imm %b valid %b)",
               tag, act, exp, op, dst, src, imm, use_imm, valid);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4, 5, 6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R10";
    endcase
  endfunction

  // One issue cycle: drive on falling edge, check outputs, then flags after the edge.
  task automatic apply(input int o, input logic [15:0] d, input logic [15:0] a,
                       input logic ui, input logic v);
    logic [15:0] s, im, x, er;
    logic ew;
    int sd;
    logic [4:0] nf;
    s  = ui ? ~a : a;     // unused source carries a conflicting value (R9)
    im = ui ? a : ~a;
    x  = a;
    @(negedge clk);
    valid = v; op = 4'(o); use_imm = ui; dst = d; src = s; imm = im;
    #1;
    ew = v && (o <= 8) && (o != 2);
    nf = exp_flags;
    case (o)
      0: er = d + x;
      1: er = d - x;
      3: er = d & x;
      4: er = d | x;
      5: er = d ^ x;
      6: er = x;
      7: er = ($signed(x) > 0) ? (d << 1) : (($signed(x) < 0) ? (d >> 1) : d);
      8: er = {im[7:0], 8'h00};
      default: er = '0;
    endcase
    if (!ew) er = '0;
    check(v ? tag_of(o) : "R10", {31'd0, wr_en}, {31'd0, ew});
    check(v ? tag_of(o) : "R10", {16'd0, result}, {16'd0, er});
    if (v && o == 0) begin
      sd = int'($signed(d)) + int'($signed(x));
      nf[0] = (32'(d) + 32'(x)) > 32'hFFFF;
      nf[1] = (sd > 32767) || (sd < -32768);
    end else if (v && o == 1) begin
      sd = int'($signed(d)) - int'($signed(x));
      nf[0] = (d >= x);
      nf[1] = (sd > 32767) || (sd < -32768);
    end else if (v && o == 2) begin
      nf[4] = (d == x);
      nf[3] = ($signed(d) < $signed(x));
      nf[2] = (d < x);
    end
    @(posedge clk);
    #1;
    exp_flags = nf;
    check((v && o <= 2) ? tag_of(o) : "R2", {27'd0, flags}, {27'd0, exp_flags});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h007F, 16'h0080, 16'h00FF, 16'h0100, 16'h1234,
             16'h5555, 16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001, 16'hAAAA, 16'hFFFE, 16'hFFFF};
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1", {27'd0, flags}, 32'd0);
    check("R10", {31'd0, wr_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Full sweep of each defined opcode; operand source alternates (R9)
    for (int o = 0; o <= 8; o++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(o, vals[i], vals[j], 1'((i + j) % 2), 1'b1);

    // R9: explicit source selection with MOV
    apply(6, 16'h0000, 16'hBEEF, 1'b1, 1'b1);
    apply(6, 16'h0000, 16'hBEEF, 1'b0, 1'b1);

    // R2/R10: undefined opcodes keep flags and write nothing
    apply(2, 16'h0005, 16'h0005, 1'b0, 1'b1);
    for (int o = 9; o < 16; o++)
      for (int i = 0; i < 16; i += 3)
        apply(o, vals[i], vals[15 - i], 1'(i % 2), 1'b1);

    // R2/R10: idle cycles carrying flag-setting opcodes
    apply(0, 16'hFFFF, 16'h0001, 1'b0, 1'b1);
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 16; i++)
        apply(o, vals[i], vals[(i * 7) % 16], 1'b0, 1'b0);

    // R1: reset clears flags set by earlier operations
    apply(2, 16'h0000, 16'h0001, 1'b0, 1'b1);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", {27'd0, flags}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule